// File: doc/BRIEF.md
# Polling Bus Arbiter

This block decides which of several devices may drive a shared bus. There is no per-device grant wire. Every device raises its own request, and these requests are merged into one common request line. While that line is high, the arbiter steps device addresses onto a set of poll lines. The order of those addresses comes from a writable sequence register.

Each device holds a fixed address and a small match cell. When a device sees its own address polled while it is requesting, and it is not marked as faulty, it takes ownership of the bus and raises the shared BUSY line. Polling then stops until BUSY drops. A device's priority is simply the position of its address in the sequence. Software can therefore change priority by rewriting the sequence while the arbiter is idle. An entry whose device is absent or has failed gets no answer, and the arbiter moves on one clock later.

Top module: `poll_arbiter`

## Requirements
- R1: After reset, poll_valid, bus_busy and dev_own are all low, and poll_addr is zero.
- R2: bus_req is high exactly when at least one bit of dev_req is high.
- R3: One clock after bus_req and bus_busy are both low, poll_valid is low. Whenever poll_valid is low, poll_addr reads zero.
- R4: When bus_req rises from idle, the next clock polls sequence entry 0. Each entry is held for exactly one clock. The arbiter then moves to the next entry, and it wraps from entry SEQ_LEN-1 back to entry 0.
- R5: Device k answers to address k. The clock after its address is polled while dev_req[k] is high and dev_fault[k] is low, dev_own[k] and bus_busy go high. While bus_busy is high, poll_valid stays low, and at most one device owns the bus.
- R6: An owning device keeps ownership while its request stays high. It releases ownership on the clock after its request falls.
- R7: When several devices request at once, the one whose address appears earliest in the sequence wins.
- R8: An entry whose address has no device, or whose device has dev_fault set, gets no answer. Polling moves to the next entry after one clock.
- R9: When bus_busy falls and bus_req is still high, polling restarts at sequence entry 0 on the next clock.
- R10: A write on seq_wr_en takes effect only while the arbiter is idle (not polling and not holding a granted bus). A write at any other time is dropped.
- R11: Sequence entry k occupies bits [k*ADDR_W +: ADDR_W] of seq_wr_data. After reset, entry k holds address k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_req | input | N_DEV | Per-device bus request |
| dev_fault | input | N_DEV | Per-device failure flag; a flagged device never answers a poll |
| seq_wr_en | input | 1 | Sequence register write strobe |
| seq_wr_data | input | SEQ_LEN*ADDR_W | New poll order, entry k at bits [k*ADDR_W +: ADDR_W] |
| bus_req | output | 1 | Shared request line (OR of all requests) |
| poll_valid | output | 1 | Poll lines carry a valid address |
| poll_addr | output | ADDR_W | Address currently polled |
| bus_busy | output | 1 | Shared BUSY line: some device owns the bus |
| dev_own | output | N_DEV | One-hot owner of the bus |

## Verification
A wrong sequence index shows up on poll_addr within one clock of the first poll. The tests therefore compare the full address stream, including the wrap and the restart after BUSY falls. A stale or wrongly gated sequence register shows only at the next poll after a write. For this reason, a write issued while the bus is held is followed by a release, and the first resumed address must still come from the earlier order. A match cell that fires on the wrong address or ignores its fault flag changes dev_own one clock after the poll. The tests sample dev_own at that point for both absent and faulted entries.

// File: rtl/poll_arb_pkg.sv
package poll_arb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_POLL = 2'd1,
        ST_HOLD = 2'd2
    } poll_state_e;

endpackage

// File: rtl/poll_seq_reg.sv
module poll_seq_reg #(
    parameter int ADDR_W  = 3,
    parameter int SEQ_LEN = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en_i,
    input  logic                      wr_allow_i,
    input  logic [SEQ_LEN*ADDR_W-1:0] wr_data_i,
    output logic [SEQ_LEN*ADDR_W-1:0] seq_o
);

    localparam int SEQ_W = SEQ_LEN * ADDR_W;

    typedef struct packed {
        logic [SEQ_W-1:0] order;
    } seq_t;

    seq_t seq_d, seq_q;

    // Reset order: entry k holds address k
    function automatic logic [SEQ_W-1:0] reset_order();
        logic [SEQ_W-1:0] r;
        r = '0;
        for (int k = 0; k < SEQ_LEN; k++) begin
            r[k*ADDR_W +: ADDR_W] = ADDR_W'(k);
        end
        return r;
    endfunction

    always_comb begin
        seq_d = seq_q;
        if (wr_en_i && wr_allow_i) begin
            seq_d.order = wr_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.order <= reset_order();
        end else begin
            seq_q <= seq_d;
        end
    end

    assign seq_o = seq_q.order;

endmodule

// File: rtl/poll_engine.sv
module poll_engine
    import poll_arb_pkg::*;
#(
    parameter int ADDR_W  = 3,
    parameter int SEQ_LEN = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [SEQ_LEN*ADDR_W-1:0] seq_i,
    input  logic                      bus_req_i,
    input  logic                      any_hit_i,
    input  logic                      bus_busy_i,
    output logic [ADDR_W-1:0]         poll_addr_o,
    output logic                      poll_valid_o,
    output logic                      idle_o
);

    localparam int IDX_W = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SEQ_LEN - 1);

    typedef struct packed {
        poll_state_e      st;
        logic [IDX_W-1:0] idx;
    } eng_t;

    eng_t eng_d, eng_q;
    logic [ADDR_W-1:0] sel_addr;

    // Select the sequence entry under the index
    always_comb begin
        sel_addr = '0;
        for (int k = 0; k < SEQ_LEN; k++) begin
            if (eng_q.idx == IDX_W'(k)) begin
                sel_addr = seq_i[k*ADDR_W +: ADDR_W];
            end
        end
    end

    always_comb begin
        eng_d = eng_q;
        unique case (eng_q.st)
            ST_IDLE: begin
                if (bus_req_i) begin
                    eng_d.st  = ST_POLL;
                    eng_d.idx = '0;
                end
            end
            ST_POLL: begin
                if (any_hit_i) begin
                    eng_d.st = ST_HOLD;
                end else if (!bus_req_i) begin
                    eng_d.st  = ST_IDLE;
                    eng_d.idx = '0;
                end else if (eng_q.idx == LAST_IDX) begin
                    eng_d.idx = '0;
                end else begin
                    eng_d.idx = eng_q.idx + 1'b1;
                end
            end
            ST_HOLD: begin
                if (!bus_busy_i) begin
                    eng_d.idx = '0;
                    eng_d.st  = bus_req_i ? ST_POLL : ST_IDLE;
                end
            end
            default: begin
                eng_d.st  = ST_IDLE;
                eng_d.idx = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_q.st  <= ST_IDLE;
            eng_q.idx <= '0;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign poll_valid_o = (eng_q.st == ST_POLL);
    assign poll_addr_o  = poll_valid_o ? sel_addr : '0;
    assign idle_o       = (eng_q.st == ST_IDLE);

endmodule

// File: rtl/poll_dev_cell.sv
module poll_dev_cell #(
    parameter int                ADDR_W  = 3,
    parameter logic [ADDR_W-1:0] MY_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              fault_i,
    input  logic              poll_valid_i,
    input  logic [ADDR_W-1:0] poll_addr_i,
    output logic              hit_o,
    output logic              own_o
);

    typedef struct packed {
        logic own;
    } cell_t;

    cell_t cell_d, cell_q;

    // Answer only to this cell's own address
    assign hit_o = poll_valid_i && (poll_addr_i == MY_ADDR) && req_i && !fault_i;

    always_comb begin
        cell_d = cell_q;
        if (cell_q.own) begin
            cell_d.own = req_i;
        end else begin
            cell_d.own = hit_o;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cell_q.own <= 1'b0;
        end else begin
            cell_q <= cell_d;
        end
    end

    assign own_o = cell_q.own;

endmodule

// File: rtl/poll_arbiter.sv
module poll_arbiter #(
    parameter int N_DEV   = 4,
    parameter int ADDR_W  = 3,
    parameter int SEQ_LEN = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_DEV-1:0]          dev_req,
    input  logic [N_DEV-1:0]          dev_fault,
    input  logic                      seq_wr_en,
    input  logic [SEQ_LEN*ADDR_W-1:0] seq_wr_data,
    output logic                      bus_req,
    output logic                      poll_valid,
    output logic [ADDR_W-1:0]         poll_addr,
    output logic                      bus_busy,
    output logic [N_DEV-1:0]          dev_own
);

    localparam int SEQ_W = SEQ_LEN * ADDR_W;

    logic [SEQ_W-1:0] seq;
    logic [N_DEV-1:0] hit;
    logic             idle;

    assign bus_req  = |dev_req;
    assign bus_busy = |dev_own;

    poll_seq_reg #(
        .ADDR_W (ADDR_W),
        .SEQ_LEN(SEQ_LEN)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (seq_wr_en),
        .wr_allow_i(idle),
        .wr_data_i (seq_wr_data),
        .seq_o     (seq)
    );

    poll_engine #(
        .ADDR_W (ADDR_W),
        .SEQ_LEN(SEQ_LEN)
    ) u_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .seq_i       (seq),
        .bus_req_i   (bus_req),
        .any_hit_i   (|hit),
        .bus_busy_i  (bus_busy),
        .poll_addr_o (poll_addr),
        .poll_valid_o(poll_valid),
        .idle_o      (idle)
    );

    for (genvar g = 0; g < N_DEV; g++) begin : g_cell
        poll_dev_cell #(
            .ADDR_W (ADDR_W),
            .MY_ADDR(ADDR_W'(g))
        ) u_cell (
            .clk         (clk),
            .rst_n       (rst_n),
            .req_i       (dev_req[g]),
            .fault_i     (dev_fault[g]),
            .poll_valid_i(poll_valid),
            .poll_addr_i (poll_addr),
            .hit_o       (hit[g]),
            .own_o       (dev_own[g])
        );
    end

endmodule

// File: rtl/poll_arbiter_chk.sv
module poll_arbiter_chk #(
    parameter int N_DEV  = 4,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_DEV-1:0]  dev_req,
    input logic [N_DEV-1:0]  dev_fault,
    input logic              bus_req,
    input logic              poll_valid,
    input logic [ADDR_W-1:0] poll_addr,
    input logic              bus_busy,
    input logic [N_DEV-1:0]  dev_own
);

    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_req && !bus_busy) |=> !poll_valid);

    assert_addr_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !poll_valid |-> (poll_addr == '0));

    assert_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_busy |-> !poll_valid);

    assert_single_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_own));

    assert_resume_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bus_busy) && bus_req) |=> poll_valid);

    for (genvar i = 0; i < N_DEV; i++) begin : g_dev
        localparam logic [ADDR_W-1:0] MY_A = ADDR_W'(i);

        assert_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (dev_own[i] && dev_req[i]) |=> dev_own[i]);

        assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (dev_own[i] && !dev_req[i]) |=> !dev_own[i]);

        assert_grant_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(dev_own[i]) |->
                $past(poll_valid && (poll_addr == MY_A) && dev_req[i] && !dev_fault[i]));
    end

endmodule

bind poll_arbiter poll_arbiter_chk #(
    .N_DEV (N_DEV),
    .ADDR_W(ADDR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .dev_req   (dev_req),
    .dev_fault (dev_fault),
    .bus_req   (bus_req),
    .poll_valid(poll_valid),
    .poll_addr (poll_addr),
    .bus_busy  (bus_busy),
    .dev_own   (dev_own)
);

// File: tb/poll_arbiter_tb_top.sv
`timescale 1ns/1ps
module poll_arbiter_tb_top;

    localparam int N_DEV   = 4;
    localparam int ADDR_W  = 3;
    localparam int SEQ_LEN = 6;

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic [N_DEV-1:0]          dev_req = '0;
    logic [N_DEV-1:0]          dev_fault = '0;
    logic                      seq_wr_en = 1'b0;
    logic [SEQ_LEN*ADDR_W-1:0] seq_wr_data = '0;
    logic                      bus_req;
    logic                      poll_valid;
    logic [ADDR_W-1:0]         poll_addr;
    logic                      bus_busy;
    logic [N_DEV-1:0]          dev_own;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    poll_arbiter #(
        .N_DEV  (N_DEV),
        .ADDR_W (ADDR_W),
        .SEQ_LEN(SEQ_LEN)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .dev_req    (dev_req),
        .dev_fault  (dev_fault),
        .seq_wr_en  (seq_wr_en),
        .seq_wr_data(seq_wr_data),
        .bus_req    (bus_req),
        .poll_valid (poll_valid),
        .poll_addr  (poll_addr),
        .bus_busy   (bus_busy),
        .dev_own    (dev_own)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic expect_poll(string tag, int addr);
        check({tag, " valid"}, 32'(poll_valid), 32'd1);
        check({tag, " addr"}, 32'(poll_addr), 32'(addr));
    endtask

    task automatic expect_quiet(string tag);
        check({tag, " valid"}, 32'(poll_valid), 32'd0);
        check({tag, " addr"}, 32'(poll_addr), 32'd0);
    endtask

    function automatic logic [SEQ_LEN*ADDR_W-1:0] pack6(int a0, int a1, int a2,
                                                        int a3, int a4, int a5);
        logic [SEQ_LEN*ADDR_W-1:0] r;
        r = '0;
        r[0*ADDR_W +: ADDR_W] = ADDR_W'(a0);
        r[1*ADDR_W +: ADDR_W] = ADDR_W'(a1);
        r[2*ADDR_W +: ADDR_W] = ADDR_W'(a2);
        r[3*ADDR_W +: ADDR_W] = ADDR_W'(a3);
        r[4*ADDR_W +: ADDR_W] = ADDR_W'(a4);
        r[5*ADDR_W +: ADDR_W] = ADDR_W'(a5);
        return r;
    endfunction

    task automatic test_reset();
        repeat (3) step();
        rst_n = 1'b1;
        step();
        check("R1 valid", 32'(poll_valid), 32'd0);
        check("R1 addr", 32'(poll_addr), 32'd0);
        check("R1 busy", 32'(bus_busy), 32'd0);
        check("R1 own", 32'(dev_own), 32'd0);
        check("R2 idle line", 32'(bus_req), 32'd0);
    endtask

    // Faulted sole requester: full default order streams and wraps
    task automatic test_stream_wrap();
        dev_fault = 4'b0001;
        dev_req   = 4'b0001;
        #1 check("R2 merged line", 32'(bus_req), 32'd1);
        for (int k = 0; k < 7; k++) begin
            step();
            expect_poll("R4 R11 stream", k % SEQ_LEN);
            check("R8 faulted no own", 32'(dev_own), 32'd0);
        end
        dev_req = '0;
        step();
        expect_quiet("R3 back to idle");
        dev_fault = '0;
    endtask

    task automatic test_single_grant();
        dev_req = 4'b0100;
        step(); expect_poll("R4 entry0", 0);
        step(); expect_poll("R4 entry1", 1);
        step(); expect_poll("R4 entry2", 2);
        step();
        check("R5 own", 32'(dev_own), 32'b0100);
        check("R5 busy", 32'(bus_busy), 32'd1);
        check("R5 frozen", 32'(poll_valid), 32'd0);
        for (int k = 0; k < 3; k++) begin
            step();
            check("R6 kept", 32'(dev_own), 32'b0100);
        end
        dev_req = '0;
        step();
        check("R6 released", 32'(dev_own), 32'd0);
        check("R6 busy low", 32'(bus_busy), 32'd0);
        step();
        expect_quiet("R3 idle after release");
    endtask

    task automatic test_priority_resume();
        dev_req = 4'b1010;
        step(); expect_poll("R7 entry0", 0);
        step(); expect_poll("R7 entry1", 1);
        step();
        check("R7 earlier wins", 32'(dev_own), 32'b0010);
        dev_req = 4'b1000;
        step();
        check("R9 busy low", 32'(bus_busy), 32'd0);
        check("R9 no poll yet", 32'(poll_valid), 32'd0);
        step(); expect_poll("R9 restart entry0", 0);
        step(); expect_poll("R9 entry1", 1);
        step(); expect_poll("R9 entry2", 2);
        step(); expect_poll("R9 entry3", 3);
        step();
        check("R9 grant dev3", 32'(dev_own), 32'b1000);
        dev_req = '0;
        step(); step();
        expect_quiet("R3 idle");
    endtask

    task automatic test_program();
        seq_wr_en   = 1'b1;
        seq_wr_data = pack6(3, 5, 1, 0, 2, 4);
        step();
        seq_wr_en = 1'b0;
        dev_req   = 4'b1010;
        step(); expect_poll("R10 new order first", 3);
        step();
        check("R7 R10 reprogrammed winner", 32'(dev_own), 32'b1000);
        seq_wr_en   = 1'b1;
        seq_wr_data = pack6(0, 1, 2, 3, 4, 5);
        step();
        seq_wr_en = 1'b0;
        check("R10 busy write no effect on own", 32'(dev_own), 32'b1000);
        dev_req = 4'b0010;
        step();
        check("R6 released", 32'(dev_own), 32'd0);
        step(); expect_poll("R10 write while held dropped", 3);
        step(); expect_poll("R8 missing addr polled", 5);
        step(); expect_poll("R10 entry2", 1);
        step();
        check("R10 dev1 owns", 32'(dev_own), 32'b0010);
        dev_req = '0;
        step(); step();
        expect_quiet("R3 idle");
    endtask

    task automatic test_skip();
        dev_fault = 4'b0001;
        dev_req   = 4'b0101;
        step(); expect_poll("R8 entry0", 3);
        step(); expect_poll("R8 absent addr", 5);
        check("R8 no own on absent", 32'(dev_own), 32'd0);
        step(); expect_poll("R8 entry2", 1);
        step(); expect_poll("R8 faulted addr", 0);
        step(); expect_poll("R8 entry4", 2);
        check("R8 fault skipped", 32'(dev_own), 32'd0);
        step();
        check("R8 dev2 owns", 32'(dev_own), 32'b0100);
        dev_req   = '0;
        dev_fault = '0;
        step(); step();
        expect_quiet("R3 idle");
    endtask

    initial begin
        test_reset();
        test_stream_wrap();
        test_single_grant();
        test_priority_resume();
        test_program();
        test_skip();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule